// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Overrun Detection

This block is a byte-wide serial port in which transmit and receive share one shift clock. Only the transmitter starts a transfer, so a byte is received only when the transmitter sends one. A receive-only user must still enable the transmitter and write a filler byte for every byte it expects to receive. While the byte comes in on the data-in pin, the filler goes out on the data-out pin.

The shift clock has two sources. The block can generate it from the system clock, or it can follow a clock that arrives on the clock pin from the other side. A polarity bit selects the idle level of the clock and which edge launches data. The CPU reaches the block through a small register bus. If a new byte completes while the previous one is still unread, an overrun flag is raised and no interrupt is signalled.

Top module: `sio_sync_xcvr`

## Requirements
- R1: After reset, the status register (address 2) reads 0x01, the control register (address 1) reads 0, `sclk_o` and `sdo` are high, `sclk_oe` is 1 and `rx_irq` is 0.
- R2: A transfer starts only when the transmit enable (control bit 0) is 1 and the transmit buffer (written at address 0) holds a byte. Writing the buffer clears the buffer-empty flag (status bit 0).
- R3: With the internal clock (control bit 3 = 0), `sclk_oe` is 1. `sclk_o` rests at the idle level, which is high for polarity 0 and low for polarity 1 (control bit 2). During a byte, `sclk_o` toggles every DIV+1 system cycles, where DIV is held at address 3.
- R4: Bits travel LSB first. `sdo` changes on the leading clock edge, the one away from idle (falling for polarity 0, rising for polarity 1), and `sdi` is sampled on the trailing edge.
- R5: The buffer-empty flag returns to 1 when the buffer is loaded into the shifter, and the busy flag (status bit 3) is then 1. A byte written during a transfer goes out directly after it.
- R6: A completed byte with receive enable (control bit 1) = 1 and the receive-full flag (status bit 1) = 0 stores the byte (read at address 0), sets receive-full and pulses `rx_irq` high for one cycle.
- R7: A read of address 0 clears the receive-full flag.
- R8: A byte that completes while receive-full is 1 sets the overrun flag (status bit 2). Receive-full stays 1 and `rx_irq` stays low. The stored byte is then unspecified.
- R9: Clearing receive enable clears the overrun flag. While receive enable is 0, completed bytes do not change receive-full and do not pulse `rx_irq`.
- R10: With the external clock (control bit 3 = 1), `sclk_oe` is 0 and shifting follows edges on `sclk_i`. A transfer starts only if transmit enable = 1, receive enable = 1 and the buffer holds a byte while `sclk_i` is at the idle level. Otherwise clock edges move no data and the buffer keeps its byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reading address 0 has a side effect) |
| addr | input | 2 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational |
| rx_irq | output | 1 | One-cycle receive interrupt request |
| sclk_o | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Drive enable for the clock pin |
| sclk_i | input | 1 | Clock pin input in external mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bound assertions check the following on every cycle:
- the clock rests at its idle level outside a transfer;
- the clock pin is released in external mode;
- every transfer start met its enable conditions;
- loading the shifter empties the buffer;
- the interrupt is one cycle long and always comes with receive-full;
- an overrun never raises the interrupt;
- receive disable clears the overrun flag.

Only the bench scenarios can show:
- bit order and edge placement for each polarity;
- the half-period length set by the divisor;
- back-to-back bytes that turn into an overrun;
- an external clock that moves nothing while receive is disabled.

// File: rtl/sio_sync_xcvr.sv
module sio_sync_xcvr #(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rx_irq,
  output logic          sclk_o,
  output logic          sclk_oe,
  input  logic          sclk_i,
  output logic          sdo,
  input  logic          sdi
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic            tx_en, rx_en, pol, ext;
  logic [DIVW-1:0] div, cnt;
  logic [DW-1:0]   txbuf, txsh, rxsh, rxbuf;
  logic            tx_empty, rx_full, ovr, busy, lvl, sdo_q, irq_q;
  logic [CW-1:0]   nbit;
  logic [2:0]      sync;

  wire idle     = ~pol;
  wire wr_tx    = wr_en && addr == 2'd0;
  wire wr_ctl   = wr_en && addr == 2'd1;
  wire wr_div   = wr_en && addr == 2'd3;
  wire rd_rx    = rd_en && addr == 2'd0;
  wire ext_idle = sync[1] == idle;
  wire start    = !busy && tx_en && !tx_empty && (!ext || (rx_en && ext_idle));
  wire tick     = busy && !ext && cnt == div;
  wire lead     = busy && (ext ? (sync[2] == idle && sync[1] != idle) : (tick && lvl == idle));
  wire trail    = busy && (ext ? (sync[2] != idle && sync[1] == idle) : (tick && lvl != idle));
  wire last     = trail && nbit == CW'(DW - 1);
  wire full_eff = rx_full && !rd_rx;
  wire [DW-1:0] rx_next = {sdi, rxsh[DW-1:1]};

  assign sclk_o  = (busy && !ext) ? lvl : idle;
  assign sclk_oe = !ext;
  assign sdo     = sdo_q;
  assign rx_irq  = irq_q;

  always_comb begin
    case (addr)
      2'd0:    rdata = rxbuf;
      2'd1:    rdata = {{(DW-4){1'b0}}, ext, pol, rx_en, tx_en};
      2'd2:    rdata = {{(DW-4){1'b0}}, busy, ovr, rx_full, tx_empty};
      default: rdata = DW'(div);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], sclk_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ext, pol, rx_en, tx_en} <= '0;
      div      <= '0;
      cnt      <= '0;
      txbuf    <= '0;
      txsh     <= '0;
      rxsh     <= '0;
      rxbuf    <= '0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      ovr      <= 1'b0;
      busy     <= 1'b0;
      lvl      <= 1'b1;
      sdo_q    <= 1'b1;
      irq_q    <= 1'b0;
      nbit     <= '0;
    end else begin
      irq_q <= 1'b0;
      if (wr_ctl) {ext, pol, rx_en, tx_en} <= wdata[3:0];
      if (wr_div) div <= wdata[DIVW-1:0];
      if (rd_rx)  rx_full <= 1'b0;

      if (start) begin
        txsh     <= txbuf;
        tx_empty <= 1'b1;
        busy     <= 1'b1;
        nbit     <= '0;
        cnt      <= '0;
        lvl      <= idle;
      end
      if (wr_tx) begin
        txbuf    <= wdata;
        tx_empty <= 1'b0;
      end

      if (busy && !ext) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) lvl <= ~lvl;
      end
      if (lead) begin
        sdo_q <= txsh[0];
        txsh  <= txsh >> 1;
      end
      if (trail) begin
        rxsh <= rx_next;
        nbit <= nbit + 1'b1;
      end
      if (last) begin
        busy <= 1'b0;
        if (rx_en) begin
          if (full_eff) ovr <= 1'b1;
          else begin
            rxbuf   <= rx_next;
            rx_full <= 1'b1;
            irq_q   <= 1'b1;
          end
        end
      end
      if (!rx_en) ovr <= 1'b0;
    end
  end
endmodule

module sio_sync_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic ext,
  input logic pol,
  input logic tx_en,
  input logic rx_en,
  input logic tx_empty,
  input logic rx_full,
  input logic ovr,
  input logic wr_tx,
  input logic sclk_o,
  input logic sclk_oe,
  input logic rx_irq
);
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ext) |-> sclk_o == ~pol);
  a_r10_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
    ext |-> !sclk_oe);
  a_r10_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(tx_en) && (!$past(ext) || $past(rx_en))));
  a_r5_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(wr_tx)) |-> tx_empty);
  a_r6_irq_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  a_r8_ovr_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> (!rx_irq && rx_full));
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !ovr);
endmodule

bind sio_sync_xcvr sio_sync_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ext(ext), .pol(pol),
  .tx_en(tx_en), .rx_en(rx_en), .tx_empty(tx_empty), .rx_full(rx_full),
  .ovr(ovr), .wr_tx(wr_tx), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
  .rx_irq(rx_irq)
);

// File: tb/test_sio_sync_xcvr.sv
module test_sio_sync_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rx_irq, sclk_o, sclk_oe, sdo;
  logic       sclk_drv = 1'b1;
  logic       sdi = 1'b0;

  int nchk = 0, nfail = 0, irq_cnt = 0;
  logic       hold = 1'b1, use_ext = 1'b0, pol_tb = 1'b0;
  int         div_tb = 0;
  logic [7:0] sl_q[$], got[$];
  logic [7:0] sl_cur = 8'hFF, cap = 8'h00;
  int         mbits = 0, gap = 0;
  logic       line_prev = 1'b1;

  always #5 clk = ~clk;

  sio_sync_xcvr i_sio_sync_xcvr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_irq(rx_irq), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .sclk_i(sclk_drv), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference line model: decodes edges at the pins, feeds sdi, collects sdo
  always @(negedge clk) begin
    logic cur;
    cur = use_ext ? sclk_drv : sclk_o;
    if (rst_n && rx_irq) irq_cnt++;
    if (!rst_n || hold) begin
      mbits = 0; gap = 0;
    end else if (cur != line_prev) begin
      if (line_prev == ~pol_tb) begin
        if (mbits == 0) sl_cur = (sl_q.size() > 0) ? sl_q.pop_front() : 8'hFF;
        else if (!use_ext) chk(gap == div_tb, "R3 half period", gap, div_tb);
        sdi = sl_cur[mbits];
      end else begin
        if (!use_ext) chk(gap == div_tb, "R3 half period", gap, div_tb);
        cap[mbits] = sdo;
        mbits++;
        if (mbits == 8) begin
          got.push_back(cap);
          mbits = 0;
        end
      end
      gap = 0;
    end else gap++;
    line_prev = cur;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); #1; rd_en = 1'b1; addr = a; #1; d = rdata;
    @(negedge clk); #1; rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 2000; k++) begin
      rd(2'd2, s);
      if (!s[3]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic ext_byte();
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); #1; sclk_drv = pol_tb;
      repeat (6) @(negedge clk);
      #1; sclk_drv = ~pol_tb;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic configure(input logic [7:0] ctl);
    hold = 1'b1;
    pol_tb = ctl[2];
    use_ext = ctl[3];
    wr(2'd1, ctl);
    repeat (2) @(negedge clk);
    hold = 1'b0;
  endtask

  task automatic got_chk(input string req, input logic [7:0] exp);
    logic [7:0] g;
    g = (got.size() > 0) ? got.pop_front() : 8'hxx;
    chk(g === exp, req, g, exp);
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int         ic;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd2, s); chk(s == 8'h01, "R1 status", s, 8'h01);
    rd(2'd1, s); chk(s == 8'h00, "R1 control", s, 8'h00);
    chk(sclk_o && sdo && sclk_oe && !rx_irq, "R1 pins", {sclk_o, sdo, sclk_oe, rx_irq}, 4'b1110);

    div_tb = 1;
    wr(2'd3, 8'd1);
    hold = 1'b0;
    // R2 no transfer without transmit enable
    wr(2'd0, 8'h5A);
    repeat (40) @(negedge clk);
    rd(2'd2, s); chk(s == 8'h00, "R2 buffer held, idle", s, 8'h00);
    chk(got.size() == 0 && sclk_o, "R2 no clock", got.size(), 0);

    // R4 R6 first byte, polarity 0
    sl_q.push_back(8'h3C);
    configure(8'h03);
    wait_idle();
    got_chk("R4 sdo LSB first pol0", 8'h5A);
    rd(2'd2, s); chk(s == 8'h03, "R6 full after byte", s, 8'h03);
    chk(irq_cnt == 1, "R6 irq pulse", irq_cnt, 1);
    rd(2'd0, s); chk(s == 8'h3C, "R6 received byte", s, 8'h3C);
    rd(2'd2, s); chk(s == 8'h01, "R7 read clears full", s, 8'h01);

    // R5 back to back, R8 overrun on second
    sl_q.push_back(8'h81); sl_q.push_back(8'h7E);
    wr(2'd0, 8'h11);
    rd(2'd2, s); chk(s == 8'h09, "R5 empty and busy after load", s, 8'h09);
    wr(2'd0, 8'h22);
    for (int k = 0; k < 500 && got.size() < 2; k++) @(negedge clk);
    wait_idle();
    got_chk("R5 first of pair", 8'h11);
    got_chk("R5 second of pair", 8'h22);
    rd(2'd2, s); chk(s == 8'h07, "R8 overrun flags", s, 8'h07);
    chk(irq_cnt == 2, "R8 no irq on overrun", irq_cnt, 2);

    // R9 receive disable clears overrun, blocks reception
    configure(8'h01);
    rd(2'd2, s); chk(s == 8'h03, "R9 overrun cleared", s, 8'h03);
    rd(2'd0, s);
    rd(2'd2, s); chk(s == 8'h01, "R7 cleared again", s, 8'h01);
    wr(2'd0, 8'h33);
    wait_idle();
    got_chk("R4 second pattern", 8'h33);
    rd(2'd2, s); chk(s == 8'h01, "R9 nothing received", s, 8'h01);
    chk(irq_cnt == 2, "R9 no irq", irq_cnt, 2);

    // R3 R4 polarity 1, divisor 2
    div_tb = 2;
    wr(2'd3, 8'd2);
    configure(8'h07);
    chk(sclk_o == 1'b0, "R3 idle low pol1", sclk_o, 0);
    sl_q.push_back(8'hC3);
    wr(2'd0, 8'h96);
    wait_idle();
    got_chk("R4 sdo pol1", 8'h96);
    rd(2'd0, s); chk(s == 8'hC3, "R4 sdi pol1", s, 8'hC3);
    chk(irq_cnt == 3, "R6 irq pol1", irq_cnt, 3);

    // R10 external clock
    sclk_drv = 1'b1;
    configure(8'h09);
    chk(sclk_oe == 1'b0, "R10 pin released", sclk_oe, 0);
    wr(2'd0, 8'h44);
    repeat (20) @(negedge clk);
    rd(2'd2, s); chk(s == 8'h00, "R10 no start rx off", s, 8'h00);
    ext_byte();
    repeat (8) @(negedge clk);
    rd(2'd2, s); chk(s == 8'h00, "R10 edges ignored", s, 8'h00);
    got.delete();
    configure(8'h0B);
    repeat (6) @(negedge clk);
    rd(2'd2, s); chk(s == 8'h09, "R10 armed", s, 8'h09);
    sl_q.delete();
    sl_q.push_back(8'h5D);
    ic = irq_cnt;
    ext_byte();
    repeat (8) @(negedge clk);
    got_chk("R10 sdo external", 8'h44);
    rd(2'd2, s); chk(s == 8'h03, "R10 status after byte", s, 8'h03);
    rd(2'd0, s); chk(s == 8'h5D, "R10 received byte", s, 8'h5D);
    chk(irq_cnt == ic + 1, "R10 irq", irq_cnt, ic + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule